// File: doc/BRIEF.md
# MEI Snooping Tag Controller

This block owns the tag store of a set-associative data cache: 128 sets of 4 ways. Each way keeps an address tag and a three-valued coherence state: Invalid, Exclusive (valid, clean, no other cache has a copy) or Modified (only this cache holds current data). Two clients share the store. The processor side issues loads, stores and line-fill installs. The bus side issues snoops. The store has one port, so it serves only one lookup per cycle.

When a snoop and a processor operation arrive in the same cycle, the snoop takes the port. The processor operation is held for exactly one clock and then runs. In the collision cycle the processor sees a one-cycle stall flag. Every operation reports hit or miss, the hit way and the state before the update. The block then updates the coherence state. A snoop that finds a Modified line raises a write-back request. The data array, the bus protocol and the choice of victim way are outside the block. The fill way is supplied by the requester.

Top module: `mei_snoop_tag_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every line is Invalid and both done flags are low. A load to any address then reports a miss.
- R2: Address bits [11:5] select the set and bits [31:12] form the tag. Bits [4:0] are ignored. The processor operation code is 0 = load, 1 = store, 2 = clean fill and 3 = dirty fill. A load reports cpu_hit, the hit way and the line state (0 = Invalid, 1 = Exclusive, 2 = Modified) with cpu_done high one cycle after it is sampled.
- R3: When snp_req and cpu_req are high in the same cycle, cpu_stall is high in that cycle and the snoop result appears one cycle later. cpu_stall stays low whenever no snoop is present.
- R4: A processor operation deferred by a snoop produces its result two cycles after it was sampled, and never one cycle after.
- R5: A store that hits an Exclusive line moves it to Modified. A store that hits a Modified line leaves it Modified.
- R6: A clean fill installs the tag in the given way as Exclusive. A dirty fill installs it as Modified.
- R7: A snoop that hits a Modified line reports snp_hit, the way and snp_wb_req, and the line becomes Invalid.
- R8: A snoop that hits an Exclusive line reports a hit without a write-back request, and the line becomes Invalid.
- R9: A snoop that misses reports neither a hit nor a write-back, and no line changes state.
- R10: A load or store that misses changes no state. A store miss does not allocate.
- R11: A deferred operation sees the update made by the snoop that displaced it. For example, a store to a line the snoop just invalidated reports a miss.
- R12: Lines with the same tag in different sets are independent. Lines with different tags in the same set occupy distinct ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor operation valid for one cycle |
| cpu_op | input | 2 | 0 load, 1 store, 2 clean fill, 3 dirty fill |
| cpu_addr | input | 32 | Processor byte address |
| cpu_fill_way | input | 2 | Way written by a fill |
| snp_req | input | 1 | Snoop valid for one cycle |
| snp_addr | input | 32 | Snooped byte address |
| cpu_stall | output | 1 | Processor operation deferred this cycle |
| cpu_done | output | 1 | Processor result valid |
| cpu_hit | output | 1 | Processor lookup hit |
| cpu_way | output | 2 | Way that hit |
| cpu_state | output | 2 | State of the hit line before update |
| snp_done | output | 1 | Snoop result valid |
| snp_hit | output | 1 | Snoop lookup hit |
| snp_way | output | 2 | Way that hit the snoop |
| snp_wb_req | output | 1 | Modified line must be written back |

## Verification
A snoop result and an uncontested processor result are due one clock after the sampling edge. A deferred processor result is due two clocks after it. cpu_stall is combinational and is valid in the request cycle itself. The driver tags each expected item with the cycle counter value at which it must appear. The monitor checks, on the falling edge, both the values and that the counter matches. Any result that arrives early, late or unannounced is counted as a failure. State changes that leave no direct trace at the ports are made visible by follow-up loads or snoops.

// File: rtl/mei_tag_pkg.sv
// Shared encodings for the MEI tag controller.
// Assumes: 2-bit state and operation fields are used everywhere.
package mei_tag_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_EXC = 2'b01,
        ST_MOD = 2'b10
    } mei_e;

    typedef enum logic [1:0] {
        OP_LOAD       = 2'b00,
        OP_STORE      = 2'b01,
        OP_FILL_CLEAN = 2'b10,
        OP_FILL_DIRTY = 2'b11
    } cpu_op_e;
endpackage

// File: rtl/mei_tag_array.sv
// Tag and state storage, SETS x WAYS, one read set and one write per cycle.
// Read is combinational on rd_idx; a write lands at the clock edge.
// Assumes: only the state field needs reset, tags are qualified by state.
module mei_tag_array #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [WAYS*TAG_W-1:0] rd_tags,
    output logic [WAYS*2-1:0]     rd_states,
    input  logic                  wr_en,
    input  logic                  wr_tag_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [WAY_W-1:0]      wr_way,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic [1:0]            wr_state
);
    import mei_tag_pkg::*;

    logic [TAG_W-1:0] tag_mem [SETS][WAYS];
    logic [1:0]       st_mem  [SETS][WAYS];

    // State store: cleared to Invalid on reset, updated by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_mem[s][w] <= ST_INV;
                end
            end
        end else if (wr_en) begin
            st_mem[wr_idx][wr_way] <= wr_state;
        end
    end

    // Tag store: written only when a line is installed.
    always_ff @(posedge clk) begin
        if (wr_en && wr_tag_en) begin
            tag_mem[wr_idx][wr_way] <= wr_tag;
        end
    end

    // Read port: present every way of the addressed set.
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tags[w*TAG_W +: TAG_W] = tag_mem[rd_idx][w];
        assign rd_states[w*2 +: 2]       = st_mem[rd_idx][w];
    end
endmodule

// File: rtl/mei_tag_lookup.sv
// Parallel tag compare across the ways of one set.
// Produces hit, encoded way and the state of the matching line.
// Assumes: installs only happen on misses, so at most one way matches.
module mei_tag_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active,
    input  logic [WAYS*TAG_W-1:0] tags,
    input  logic [WAYS*2-1:0]     states,
    input  logic [TAG_W-1:0]      tag,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic [1:0]            hit_state
);
    import mei_tag_pkg::*;

    logic [WAYS-1:0] hit_vec;

    // Per-way match: valid state and equal tag.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = (states[w*2 +: 2] != ST_INV) &&
                            (tags[w*TAG_W +: TAG_W] == tag);
    end

    // Encode the matching way and pick its state.
    always_comb begin
        hit_way   = '0;
        hit_state = ST_INV;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way   = WAY_W'(w);
                hit_state = states[w*2 +: 2];
            end
        end
    end

    assign hit = |hit_vec;

    // R12: a tag lives in at most one way of a set.
    assert_single_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> $onehot0(hit_vec));
endmodule

// File: rtl/mei_tag_arbiter.sv
// Grants the single tag port: snoop first, then a held processor
// operation, then a fresh processor operation.
// Assumes: the requester issues nothing in the cycle after a stall.
module mei_tag_arbiter #(
    parameter int LINE_W = 27,
    parameter int WAY_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_op,
    input  logic [LINE_W-1:0] cpu_line,
    input  logic [WAY_W-1:0]  cpu_fway,
    input  logic              snp_req,
    input  logic [LINE_W-1:0] snp_line,
    output logic              stall,
    output logic              sel_valid,
    output logic              sel_snoop,
    output logic [1:0]        sel_op,
    output logic [LINE_W-1:0] sel_line,
    output logic [WAY_W-1:0]  sel_fway
);
    import mei_tag_pkg::*;

    logic              pend_vld;
    logic [1:0]        pend_op;
    logic [LINE_W-1:0] pend_line;
    logic [WAY_W-1:0]  pend_fway;

    assign stall = snp_req && cpu_req;

    // Hold slot: captures a processor operation displaced by a snoop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_op   <= OP_LOAD;
            pend_line <= '0;
            pend_fway <= '0;
        end else begin
            pend_vld <= stall;
            if (stall) begin
                pend_op   <= cpu_op;
                pend_line <= cpu_line;
                pend_fway <= cpu_fway;
            end
        end
    end

    // Port grant in fixed priority order.
    always_comb begin
        sel_valid = 1'b0;
        sel_snoop = 1'b0;
        sel_op    = OP_LOAD;
        sel_line  = cpu_line;
        sel_fway  = cpu_fway;
        if (snp_req) begin
            sel_valid = 1'b1;
            sel_snoop = 1'b1;
            sel_line  = snp_line;
        end else if (pend_vld) begin
            sel_valid = 1'b1;
            sel_op    = pend_op;
            sel_line  = pend_line;
            sel_fway  = pend_fway;
        end else if (cpu_req) begin
            sel_valid = 1'b1;
            sel_op    = cpu_op;
        end
    end

    // R4: the slot after a deferral belongs to the held operation.
    assert_hold_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld |-> (!cpu_req && !snp_req));
endmodule

// File: rtl/mei_snoop_tag_ctrl.sv
// MEI coherence tag controller with a single-ported tag store.
// Registers each result one cycle after the lookup, and applies the
// state update at the same edge.
// Assumes: fills target a missing line; no request follows a stall.
module mei_snoop_tag_ctrl #(
    parameter int ADDR_W   = 32,
    parameter int SETS     = 128,
    parameter int WAYS     = 4,
    parameter int OFFSET_W = 5,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WAY_W-1:0]  cpu_fill_way,
    input  logic              snp_req,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              cpu_stall,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic [WAY_W-1:0]  cpu_way,
    output logic [1:0]        cpu_state,
    output logic              snp_done,
    output logic              snp_hit,
    output logic [WAY_W-1:0]  snp_way,
    output logic              snp_wb_req
);
    import mei_tag_pkg::*;

    localparam int IDX_W  = $clog2(SETS);
    localparam int LINE_W = ADDR_W - OFFSET_W;
    localparam int TAG_W  = LINE_W - IDX_W;

    logic              sel_valid, sel_snoop;
    logic [1:0]        sel_op;
    logic [LINE_W-1:0] sel_line;
    logic [WAY_W-1:0]  sel_fway;
    logic [IDX_W-1:0]  sel_idx;
    logic [TAG_W-1:0]  sel_tag;
    logic [WAYS*TAG_W-1:0] set_tags;
    logic [WAYS*2-1:0]     set_states;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic [1:0]        lk_state;
    logic              wr_en, wr_tag_en;
    logic [WAY_W-1:0]  wr_way;
    logic [1:0]        wr_state;
    logic              stall_q;
    logic              unused_offset;

    assign unused_offset = ^{cpu_addr[OFFSET_W-1:0], snp_addr[OFFSET_W-1:0]};
    assign sel_idx = sel_line[IDX_W-1:0];
    assign sel_tag = sel_line[LINE_W-1:IDX_W];

    mei_tag_arbiter #(.LINE_W(LINE_W), .WAY_W(WAY_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_op(cpu_op),
        .cpu_line(cpu_addr[ADDR_W-1:OFFSET_W]), .cpu_fway(cpu_fill_way),
        .snp_req(snp_req), .snp_line(snp_addr[ADDR_W-1:OFFSET_W]),
        .stall(cpu_stall), .sel_valid(sel_valid), .sel_snoop(sel_snoop),
        .sel_op(sel_op), .sel_line(sel_line), .sel_fway(sel_fway)
    );

    mei_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(sel_idx), .rd_tags(set_tags), .rd_states(set_states),
        .wr_en(wr_en), .wr_tag_en(wr_tag_en), .wr_idx(sel_idx),
        .wr_way(wr_way), .wr_tag(sel_tag), .wr_state(wr_state)
    );

    mei_tag_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .clk(clk), .rst_n(rst_n), .active(sel_valid),
        .tags(set_tags), .states(set_states), .tag(sel_tag),
        .hit(lk_hit), .hit_way(lk_way), .hit_state(lk_state)
    );

    // Coherence update: decide whether and what to write back to the store.
    always_comb begin
        wr_en     = 1'b0;
        wr_tag_en = 1'b0;
        wr_way    = lk_way;
        wr_state  = lk_state;
        if (sel_valid) begin
            if (sel_snoop) begin
                if (lk_hit) begin
                    wr_en    = 1'b1;
                    wr_state = ST_INV;
                end
            end else begin
                case (sel_op)
                    OP_STORE: begin
                        if (lk_hit && lk_state == ST_EXC) begin
                            wr_en    = 1'b1;
                            wr_state = ST_MOD;
                        end
                    end
                    OP_FILL_CLEAN, OP_FILL_DIRTY: begin
                        wr_en     = 1'b1;
                        wr_tag_en = 1'b1;
                        wr_way    = sel_fway;
                        wr_state  = (sel_op == OP_FILL_DIRTY) ? ST_MOD : ST_EXC;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Result registers for both clients, plus the stall history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_done   <= 1'b0;
            cpu_hit    <= 1'b0;
            cpu_way    <= '0;
            cpu_state  <= ST_INV;
            snp_done   <= 1'b0;
            snp_hit    <= 1'b0;
            snp_way    <= '0;
            snp_wb_req <= 1'b0;
            stall_q    <= 1'b0;
        end else begin
            cpu_done   <= sel_valid && !sel_snoop;
            cpu_hit    <= sel_valid && !sel_snoop && lk_hit;
            cpu_way    <= lk_way;
            cpu_state  <= lk_hit ? lk_state : ST_INV;
            snp_done   <= sel_valid && sel_snoop;
            snp_hit    <= sel_valid && sel_snoop && lk_hit;
            snp_way    <= lk_way;
            snp_wb_req <= sel_valid && sel_snoop && lk_hit && (lk_state == ST_MOD);
            stall_q    <= cpu_stall;
        end
    end

    // R3: a snoop always completes on the next cycle.
    assert_snoop_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        snp_req |=> snp_done);
    // R4: a deferred operation does not report on the next cycle...
    assert_defer_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |=> !cpu_done);
    // R4: ...and reports on the cycle after that.
    assert_defer_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall_q |=> cpu_done);
    // R7: a write-back request only comes with a snoop hit.
    assert_wb_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_wb_req |-> (snp_hit && snp_done));
endmodule

// File: tb/mei_snoop_tag_ctrl_bench.sv
module mei_snoop_tag_ctrl_bench;
    import mei_tag_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [1:0]  cpu_op = 2'b00;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_fill_way = '0;
    logic        snp_req = 1'b0;
    logic [31:0] snp_addr = '0;
    logic        cpu_stall, cpu_done, cpu_hit, snp_done, snp_hit, snp_wb_req;
    logic [1:0]  cpu_way, cpu_state, snp_way;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit fin = 1'b0;

    typedef struct {
        logic       hit;
        logic [1:0] way;
        logic [1:0] st;
        logic       wb;
        int         due;
        string      req;
    } exp_t;

    exp_t cpu_q[$];
    exp_t snp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mei_snoop_tag_ctrl u_mei_snoop_tag_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
        .cpu_addr(cpu_addr), .cpu_fill_way(cpu_fill_way),
        .snp_req(snp_req), .snp_addr(snp_addr), .cpu_stall(cpu_stall),
        .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_way(cpu_way),
        .cpu_state(cpu_state), .snp_done(snp_done), .snp_hit(snp_hit),
        .snp_way(snp_way), .snp_wb_req(snp_wb_req)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [19:0] t, logic [6:0] i, logic [4:0] off);
        return {t, i, off};
    endfunction

    // Monitor: pops the expected item when a result appears, checks its cycle.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !fin) begin
            if (cpu_done) begin
                if (cpu_q.size() == 0) check("R4", "unexpected cpu result", 1, 0);
                else begin
                    e = cpu_q.pop_front();
                    check(e.req, "cpu result cycle", cyc, e.due);
                    check(e.req, "cpu_hit", int'(cpu_hit), int'(e.hit));
                    if (e.hit) check(e.req, "cpu_way", int'(cpu_way), int'(e.way));
                    check(e.req, "cpu_state", int'(cpu_state), int'(e.st));
                end
            end else if (cpu_q.size() != 0 && cpu_q[0].due <= cyc) begin
                check(cpu_q[0].req, "cpu result missing at cycle", cyc, cpu_q[0].due - 1);
                void'(cpu_q.pop_front());
            end
            if (snp_done) begin
                if (snp_q.size() == 0) check("R3", "unexpected snoop result", 1, 0);
                else begin
                    e = snp_q.pop_front();
                    check(e.req, "snoop result cycle", cyc, e.due);
                    check(e.req, "snp_hit", int'(snp_hit), int'(e.hit));
                    if (e.hit) check(e.req, "snp_way", int'(snp_way), int'(e.way));
                    check(e.req, "snp_wb_req", int'(snp_wb_req), int'(e.wb));
                end
            end else if (snp_q.size() != 0 && snp_q[0].due <= cyc) begin
                check(snp_q[0].req, "snoop result missing at cycle", cyc, snp_q[0].due - 1);
                void'(snp_q.pop_front());
            end
        end
    end

    // Driver: one processor operation, no snoop present.
    task automatic cpu_do(logic [1:0] op, logic [31:0] a, logic [1:0] fw,
                          logic h, logic [1:0] w, logic [1:0] st, string req);
        exp_t e;
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = op; cpu_addr = a; cpu_fill_way = fw;
        e.hit = h; e.way = w; e.st = st; e.wb = 1'b0; e.due = cyc + 1; e.req = req;
        cpu_q.push_back(e);
        #1 check("R3", "stall with no snoop", int'(cpu_stall), 0);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    // Driver: one snoop, no processor operation.
    task automatic snp_do(logic [31:0] a, logic h, logic [1:0] w, logic wb, string req);
        exp_t e;
        @(negedge clk);
        snp_req = 1'b1; snp_addr = a;
        e.hit = h; e.way = w; e.st = ST_INV; e.wb = wb; e.due = cyc + 1; e.req = req;
        snp_q.push_back(e);
        @(negedge clk);
        snp_req = 1'b0;
    endtask

    // Driver: snoop and processor operation collide in one cycle.
    task automatic clash(logic [31:0] sa, logic sh, logic [1:0] sw, logic swb,
                         logic [1:0] op, logic [31:0] a, logic [1:0] fw,
                         logic h, logic [1:0] w, logic [1:0] st, string req);
        exp_t e;
        @(negedge clk);
        snp_req = 1'b1; snp_addr = sa;
        cpu_req = 1'b1; cpu_op = op; cpu_addr = a; cpu_fill_way = fw;
        e.hit = sh; e.way = sw; e.st = ST_INV; e.wb = swb; e.due = cyc + 1; e.req = "R3";
        snp_q.push_back(e);
        e.hit = h; e.way = w; e.st = st; e.wb = 1'b0; e.due = cyc + 2; e.req = req;
        cpu_q.push_back(e);
        #1 check("R3", "stall on collision", int'(cpu_stall), 1);
        @(negedge clk);
        snp_req = 1'b0; cpu_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] a_adr, b_adr, c_adr, d_adr;
        a_adr = mk(20'h12345, 7'd3, 5'h14);
        b_adr = mk(20'hABCDE, 7'd3, 5'h00);
        c_adr = mk(20'h12345, 7'd4, 5'h08);
        d_adr = mk(20'h00077, 7'd3, 5'h1F);
        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset.
        check("R1", "cpu_done in reset", int'(cpu_done), 0);
        check("R1", "snp_done in reset", int'(snp_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cpu_do(OP_LOAD, a_adr, 2'd0, 1'b0, 2'd0, ST_INV, "R1");
        // R6 / R2: clean fill then load hit.
        cpu_do(OP_FILL_CLEAN, a_adr, 2'd1, 1'b0, 2'd0, ST_INV, "R6");
        cpu_do(OP_LOAD, a_adr, 2'd0, 1'b1, 2'd1, ST_EXC, "R2");
        // R6 / R12: dirty fill to another way of the same set.
        cpu_do(OP_FILL_DIRTY, b_adr, 2'd2, 1'b0, 2'd0, ST_INV, "R6");
        cpu_do(OP_LOAD, b_adr, 2'd0, 1'b1, 2'd2, ST_MOD, "R12");
        cpu_do(OP_LOAD, a_adr, 2'd0, 1'b1, 2'd1, ST_EXC, "R12");
        cpu_do(OP_LOAD, c_adr, 2'd0, 1'b0, 2'd0, ST_INV, "R12");
        // R5: store on Exclusive, then on Modified.
        cpu_do(OP_STORE, a_adr, 2'd0, 1'b1, 2'd1, ST_EXC, "R5");
        cpu_do(OP_LOAD, a_adr, 2'd0, 1'b1, 2'd1, ST_MOD, "R5");
        cpu_do(OP_STORE, a_adr, 2'd0, 1'b1, 2'd1, ST_MOD, "R5");
        cpu_do(OP_LOAD, a_adr, 2'd0, 1'b1, 2'd1, ST_MOD, "R5");
        // R10: store miss does not allocate.
        cpu_do(OP_STORE, d_adr, 2'd0, 1'b0, 2'd0, ST_INV, "R10");
        cpu_do(OP_LOAD, d_adr, 2'd0, 1'b0, 2'd0, ST_INV, "R10");
        // R9: snoop miss leaves lines alone.
        snp_do(c_adr, 1'b0, 2'd0, 1'b0, "R9");
        cpu_do(OP_LOAD, a_adr, 2'd0, 1'b1, 2'd1, ST_MOD, "R9");
        cpu_do(OP_LOAD, b_adr, 2'd0, 1'b1, 2'd2, ST_MOD, "R9");
        // R7: snoop on Modified.
        snp_do(b_adr, 1'b1, 2'd2, 1'b1, "R7");
        cpu_do(OP_LOAD, b_adr, 2'd0, 1'b0, 2'd0, ST_INV, "R7");
        // R8: snoop on Exclusive.
        cpu_do(OP_FILL_CLEAN, c_adr, 2'd0, 1'b0, 2'd0, ST_INV, "R6");
        snp_do(c_adr, 1'b1, 2'd0, 1'b0, "R8");
        cpu_do(OP_LOAD, c_adr, 2'd0, 1'b0, 2'd0, ST_INV, "R8");
        // R11 / R4: deferred store sees the snoop's invalidation.
        clash(a_adr, 1'b1, 2'd1, 1'b1, OP_STORE, a_adr, 2'd0, 1'b0, 2'd0, ST_INV, "R11");
        cpu_do(OP_LOAD, a_adr, 2'd0, 1'b0, 2'd0, ST_INV, "R11");
        // R4: deferred load hits after a missing snoop.
        cpu_do(OP_FILL_CLEAN, b_adr, 2'd2, 1'b0, 2'd0, ST_INV, "R6");
        clash(d_adr, 1'b0, 2'd0, 1'b0, OP_LOAD, b_adr, 2'd0, 1'b1, 2'd2, ST_EXC, "R4");
        // R4: deferred dirty fill installs its line.
        clash(b_adr, 1'b1, 2'd2, 1'b0, OP_FILL_DIRTY, d_adr, 2'd3, 1'b0, 2'd0, ST_INV, "R4");
        cpu_do(OP_LOAD, d_adr, 2'd0, 1'b1, 2'd3, ST_MOD, "R4");
        repeat (3) @(negedge clk);
        check("R4", "cpu results outstanding", cpu_q.size(), 0);
        check("R3", "snoop results outstanding", snp_q.size(), 0);
        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule